// File: doc/BRIEF.md
# Cache Maintenance Command Queue

This block is the register front end through which several processors post cache maintenance work (invalidate, clean or flush) for either an address window or the entire cache. The command registers for mode, start address and length exist only once and are shared by all processors. A hardware lock settles who may use them: a processor claims the lock by writing the mode register and gives it up by reading its own registration-status register. That read is also the moment a command is committed. Registration status and completion status are kept separately for each processor.

Committed commands enter a FIFO whose depth is a parameter. A stub execution engine takes them one at a time, in the order they were accepted. Each command occupies the engine for a fixed, parameterised number of cycles. The engine announces each command as it starts, so the cache walker that would sit behind it can be modelled. A primitive register also accepts a sync code and a prefetch-flush code. When the sync code is held, a read of that register is stalled until all queued work has drained.

All access goes through a valid/ready register port that carries the requesting processor's index. Reads return data in the handshake cycle.

Top module: `maint_cmdq`

## Requirements
- R1: After reset the lock is free and the queue is empty. Every processor's completion word (offset 0x260) reads 0. The primitive register (0x244) reads 0. A registration-status read (0x25C) returns 2. exec_valid is low and req_ready is high.
- R2: A write to the mode register (0x248) claims the lock when it is free or already held by the writer. Mode bits [3:0] hold the operation: 0 invalidate, 1 clean, 2 flush. Bits [18:17] hold the scope: 0 range, 1 whole cache. Bit 15 requests a completion notice. Offsets 0x24C and 0x250 hold the start and length. When the owner reads 0x25C with the queue not full, the command is enqueued and the read returns 0.
- R3: While one processor holds the lock, mode, address and length writes from any other processor are ignored. A 0x25C read by a non-owner returns 2 (bit 1, failed) and enqueues nothing.
- R4: A 0x25C read by the owner always releases the lock. Afterwards another processor can claim the lock and commit.
- R5: If the FIFO holds DEPTH entries, the owner's 0x25C read returns 2, adds no entry and still releases the lock. The FIFO never holds more than DEPTH entries.
- R6: A mode with operation code above 2 or scope above 1 commits nothing. The owner's 0x25C read then returns 1 (bit 0) and sets that processor's error bit (0x260 bit 1). The processor's next successful commit clears the error bit.
- R7: Entries are started one at a time, in acceptance order. On an idle engine, exec_valid pulses for one cycle in the cycle after the committing read. The entry retires LAT cycles after it starts.
- R8: When an entry retires, bit 2 of 0x260 is set only for the processor that posted it, and only if its notify bit was set.
- R9: Writing a value with bit 2 set to 0x260 clears the writer's completion bit. If a retirement sets that bit in the same cycle, the set wins.
- R10: Bit 0 of 0x260 is 1 while the reading processor has at least one entry queued or executing, and 0 otherwise.
- R11: A whole-cache entry is presented with exec_all high and with address and length 0, whatever was written to 0x24C and 0x250.
- R12: Writing 8 (sync) or 9 (prefetch flush) to 0x244 stores that code, and reads of 0x244 return it. While 8 is stored and the FIFO is non-empty, a read of 0x244 is held off (req_ready low) until the last entry retires.
- R13: A write to 0x244 of any value other than 8 or 9 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Access accepted this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_cpu | input | CW | Index of the requesting processor |
| req_addr | input | 12 | Register offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the handshake cycle |
| exec_valid | output | 1 | One-cycle pulse as an entry starts |
| exec_cpu | output | CW | Poster of the starting entry |
| exec_op | output | 2 | Operation of the starting entry |
| exec_all | output | 1 | Whole-cache scope |
| exec_addr | output | AW | Start address (0 for whole cache) |
| exec_size | output | AW | Length (0 for whole cache) |

## Verification
Two pairs of events can land on one edge. The first pair is a retirement that sets a processor's completion bit and that processor's own write clearing the bit. The bench posts a notified command, waits exactly LAT idle cycles and then issues the clearing write, so that both fall on the retirement edge; the bit must then read as set. The second pair is a commit and a retirement on the same edge. This is provoked by back-to-back whole-cache registrations against a slow engine until the FIFO reports full; the bench then checks that no entry was lost or duplicated and that the start order matches the acceptance order.

// File: rtl/maint_cmdq.sv
module maint_cmdq #(
  parameter int NCPU  = 2,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int LAT   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0] req_cpu,
  input  logic [11:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  output logic                 exec_valid,
  output logic [((NCPU>1)?$clog2(NCPU):1)-1:0] exec_cpu,
  output logic [1:0]           exec_op,
  output logic                 exec_all,
  output logic [AW-1:0]        exec_addr,
  output logic [AW-1:0]        exec_size
);
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_ADDR = 12'h24C,
                          A_SIZE = 12'h250, A_REG  = 12'h25C, A_DONE = 12'h260;

  logic          lock_held;
  logic [CW-1:0] lock_cpu;
  logic [3:0]    m_op;
  logic [1:0]    m_scope;
  logic          m_ntf;
  logic [AW-1:0] m_addr, m_size;
  logic [3:0]    prim;
  logic [PW:0]   count;
  logic [PW-1:0] wp, rp;
  logic          run;
  logic [TW-1:0] cnt;
  logic [NCPU-1:0] done, err;
  logic [PW:0]   pend [NCPU];

  logic [CW-1:0] q_cpu  [DEPTH];
  logic [1:0]    q_op   [DEPTH];
  logic          q_all  [DEPTH];
  logic          q_ntf  [DEPTH];
  logic [AW-1:0] q_addr [DEPTH];
  logic [AW-1:0] q_size [DEPTH];

  wire busy   = count != '0;
  assign req_ready = !(req_valid && !req_write && req_addr == A_PRIM && prim == 4'h8 && busy);
  wire hs     = req_valid && req_ready;
  wire wr     = hs && req_write;
  wire rd     = hs && !req_write;
  wire owner  = lock_held && lock_cpu == req_cpu;
  wire bad    = m_op > 4'd2 || m_scope > 2'd1;
  wire full   = count == (PW+1)'(DEPTH);
  wire rd_reg = rd && req_addr == A_REG;
  wire push   = rd_reg && owner && !bad && !full;
  wire start  = !run && busy;
  wire fin    = run && cnt == '0;
  wire whole  = m_scope[0];

  logic [1:0] reg_sts;
  assign reg_sts = !owner ? 2'b10 : bad ? 2'b01 : full ? 2'b10 : 2'b00;

  always_comb begin
    rsp_rdata = '0;
    case (req_addr)
      A_PRIM:  rsp_rdata = {28'd0, prim};
      A_REG:   rsp_rdata = {30'd0, reg_sts};
      A_DONE:  rsp_rdata = {29'd0, done[req_cpu], err[req_cpu], pend[req_cpu] != '0};
      default: rsp_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_cpu[wp]  <= req_cpu;
      q_op[wp]   <= m_op[1:0];
      q_all[wp]  <= whole;
      q_ntf[wp]  <= m_ntf;
      q_addr[wp] <= whole ? '0 : m_addr;
      q_size[wp] <= whole ? '0 : m_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_held <= 1'b0; lock_cpu <= '0;
      m_op <= '0; m_scope <= '0; m_ntf <= 1'b0; m_addr <= '0; m_size <= '0;
      prim <= '0; count <= '0; wp <= '0; rp <= '0; run <= 1'b0; cnt <= '0;
      exec_valid <= 1'b0; exec_cpu <= '0; exec_op <= '0; exec_all <= 1'b0;
      exec_addr <= '0; exec_size <= '0;
      done <= '0; err <= '0;
      for (int c = 0; c < NCPU; c++) pend[c] <= '0;
    end else begin
      if (wr && req_addr == A_MODE && (!lock_held || owner)) begin
        lock_held <= 1'b1;
        lock_cpu  <= req_cpu;
        m_op      <= req_wdata[3:0];
        m_scope   <= req_wdata[18:17];
        m_ntf     <= req_wdata[15];
      end
      if (wr && req_addr == A_ADDR && owner) m_addr <= req_wdata[AW-1:0];
      if (wr && req_addr == A_SIZE && owner) m_size <= req_wdata[AW-1:0];
      if (rd_reg && owner) lock_held <= 1'b0;
      if (wr && req_addr == A_PRIM && req_wdata[31:1] == 31'd4) prim <= req_wdata[3:0];

      if (push) wp <= wp + 1'b1;
      if (fin)  rp <= rp + 1'b1;
      count <= count + (PW+1)'(push) - (PW+1)'(fin);

      exec_valid <= start;
      if (start) begin
        run <= 1'b1;
        cnt <= TW'(LAT - 1);
        exec_cpu  <= q_cpu[rp];
        exec_op   <= q_op[rp];
        exec_all  <= q_all[rp];
        exec_addr <= q_addr[rp];
        exec_size <= q_size[rp];
      end else if (run) begin
        if (cnt == '0) run <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end

      for (int c = 0; c < NCPU; c++) begin
        if (wr && req_addr == A_DONE && req_wdata[2] && req_cpu == CW'(c)) done[c] <= 1'b0;
        if (fin && q_ntf[rp] && q_cpu[rp] == CW'(c)) done[c] <= 1'b1;
        if (rd_reg && owner && bad && req_cpu == CW'(c)) err[c] <= 1'b1;
        else if (push && req_cpu == CW'(c)) err[c] <= 1'b0;
        pend[c] <= pend[c] + (PW+1)'(push && req_cpu == CW'(c))
                           - (PW+1)'(fin && q_cpu[rp] == CW'(c));
      end
    end
  end
endmodule

module maint_cmdq_chk #(
  parameter int NCPU  = 2,
  parameter int DEPTH = 4,
  parameter int CW    = 1,
  parameter int PW    = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [CW-1:0]   req_cpu,
  input logic [11:0]     req_addr,
  input logic [31:0]     rsp_rdata,
  input logic [PW:0]     count,
  input logic            exec_valid,
  input logic            fin,
  input logic            lock_held,
  input logic [CW-1:0]   lock_cpu,
  input logic [NCPU-1:0] done
);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH));
  // R7
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |=> !exec_valid);
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done)) != '0) |-> $past(fin));
  // R4
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == 12'h25C && lock_held && req_cpu == lock_cpu)
      |=> !lock_held);
  // R12
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == 12'h244 && rsp_rdata == 32'd8) |-> count == '0);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> req_ready);
endmodule

bind maint_cmdq maint_cmdq_chk #(.NCPU(NCPU), .DEPTH(DEPTH), .CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_cpu(req_cpu), .req_addr(req_addr), .rsp_rdata(rsp_rdata),
  .count(count), .exec_valid(exec_valid), .fin(fin), .lock_held(lock_held),
  .lock_cpu(lock_cpu), .done(done));

// File: tb/sim_maint_cmdq.sv
`timescale 1ns/1ps
module sim_maint_cmdq;
  localparam int LAT = 6;
  localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_ADDR = 12'h24C,
                          A_SIZE = 12'h250, A_REG  = 12'h25C, A_DONE = 12'h260;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [0:0] req_cpu = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, exec_valid, exec_all;
  logic [31:0] rsp_rdata, exec_addr, exec_size;
  logic [0:0] exec_cpu;
  logic [1:0] exec_op;

  maint_cmdq #(.NCPU(2), .DEPTH(4), .AW(32), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .exec_valid(exec_valid), .exec_cpu(exec_cpu), .exec_op(exec_op),
    .exec_all(exec_all), .exec_addr(exec_addr), .exec_size(exec_size));

  always #10 clk = ~clk;

  int cyc = 0, nchk = 0, nerr = 0, n = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ecyc [64]; logic [0:0] ecpu [64]; logic [1:0] eop [64];
  logic eall [64]; logic [31:0] eaddr [64], esize [64];
  always @(negedge clk)
    if (rst_n && exec_valid && n < 64) begin
      ecyc[n] = cyc; ecpu[n] = exec_cpu; eop[n] = exec_op; eall[n] = exec_all;
      eaddr[n] = exec_addr; esize[n] = exec_size; n = n + 1;
    end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int cpu, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int at, output int smp);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_cpu = 1'(cpu); req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    q = rsp_rdata; smp = cyc;
    @(posedge clk); #1;
    at = cyc;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q; int at, smp;
    acc(1'b1, cpu, a, d, q, at, smp);
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] q);
    int at, smp;
    acc(1'b0, cpu, a, 32'd0, q, at, smp);
  endtask

  task automatic post(input int cpu, input int op, input bit all, input bit ntf,
                      input logic [31:0] ad, input logic [31:0] sz,
                      output logic [31:0] sts, output int at);
    int smp;
    wr(cpu, A_MODE, 32'(op) | (32'(all) << 17) | (32'(ntf) << 15));
    if (!all) begin wr(cpu, A_ADDR, ad); wr(cpu, A_SIZE, sz); end
    acc(1'b0, cpu, A_REG, 32'd0, sts, at, smp);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #4000000;
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] q, sts;
    int at, smp, c0, n0, na;
    logic [1:0] aops [16];
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 exec_valid", 32'(exec_valid), 0);
    rd(0, A_DONE, q); chk("R1 done cpu0", q, 0);
    rd(1, A_DONE, q); chk("R1 done cpu1", q, 0);
    rd(0, A_REG, q);  chk("R1 reg no lock", q, 2);
    rd(0, A_PRIM, q); chk("R1 prim", q, 0);

    // sweep over cpu, op, scope, notify: R2 R7 R8 R10 R11
    for (int cpu = 0; cpu < 2; cpu++)
      for (int op = 0; op < 3; op++)
        for (int all = 0; all < 2; all++)
          for (int ntf = 0; ntf < 2; ntf++) begin
            int k, tdone; bit gone;
            logic [31:0] ad, sz, dq;
            k = cpu*12 + op*4 + all*2 + ntf;
            ad = 32'h1000 * (k + 1) + 32'(k); sz = 32'h40 * (k + 1);
            n0 = n;
            post(cpu, op, 1'(all), 1'(ntf), ad, sz, sts, c0);
            chk("R2 commit status", sts, 0);
            rd(cpu, A_DONE, q); chk("R10 pending own", 32'(q[0]), 1);
            rd(1 - cpu, A_DONE, q); chk("R10 pending other", 32'(q[0]), 0);
            gone = 0; tdone = 0; dq = 0;
            for (int i = 0; i < 40 && !gone; i++) begin
              acc(1'b0, cpu, A_DONE, 32'd0, q, at, smp);
              if (!q[0]) begin gone = 1; tdone = smp; dq = q; end
            end
            chk("R7 retire cycle", 32'(tdone), 32'(c0 + 1 + LAT));
            chk("R8 done own", 32'(dq[2]), 32'(ntf));
            rd(1 - cpu, A_DONE, q); chk("R8 done other", 32'(q[2]), 0);
            chk("R7 one start", 32'(n - n0), 1);
            chk("R7 start cycle", 32'(ecyc[n0]), 32'(c0 + 1));
            chk("R2 exec cpu", 32'(ecpu[n0]), 32'(cpu));
            chk("R2 exec op", 32'(eop[n0]), 32'(op));
            chk("R11 exec all", 32'(eall[n0]), 32'(all));
            chk("R11 exec addr", eaddr[n0], all ? 32'd0 : ad);
            chk("R11 exec size", esize[n0], all ? 32'd0 : sz);
            wr(cpu, A_DONE, 32'h4);
            rd(cpu, A_DONE, q); chk("R9 cleared", 32'(q[2]), 0);
          end

    // R3 R4 lock contention
    n0 = n;
    wr(0, A_MODE, 32'h1);
    wr(1, A_MODE, 32'h2 | (32'h1 << 17));
    rd(1, A_REG, q); chk("R3 non-owner status", q, 2);
    wr(1, A_ADDR, 32'hDEAD0000);
    wr(0, A_SIZE, 32'h80);
    wr(1, A_SIZE, 32'hBEEF);
    wr(0, A_ADDR, 32'h100);
    wr(1, A_ADDR, 32'hDEAD0000);
    rd(0, A_REG, q); chk("R3 owner commit", q, 0);
    idle(LAT + 4);
    chk("R3 one entry", 32'(n - n0), 1);
    chk("R3 entry cpu", 32'(ecpu[n0]), 0);
    chk("R3 entry op", 32'(eop[n0]), 1);
    chk("R3 entry addr", eaddr[n0], 32'h100);
    chk("R3 entry size", esize[n0], 32'h80);
    post(1, 2, 1'b1, 1'b0, 0, 0, sts, at);
    chk("R4 other commits", sts, 0);
    idle(LAT + 4);
    chk("R4 entry cpu", 32'(ecpu[n0 + 1]), 1);
    chk("R4 entry op", 32'(eop[n0 + 1]), 2);

    // R6 bad code
    n0 = n;
    wr(0, A_MODE, 32'h5);
    rd(0, A_REG, q); chk("R6 bad op status", q, 1);
    rd(0, A_DONE, q); chk("R6 err bit", 32'(q[1]), 1);
    wr(0, A_MODE, 32'h3 << 17);
    rd(0, A_REG, q); chk("R6 bad scope status", q, 1);
    idle(LAT + 4);
    chk("R6 nothing queued", 32'(n - n0), 0);
    post(0, 0, 1'b1, 1'b0, 0, 0, sts, at);
    rd(0, A_DONE, q); chk("R6 err cleared", 32'(q[1]), 0);
    idle(LAT + 4);

    // R5 R7 fill the FIFO against the slow engine
    n0 = n; na = 0; sts = 0;
    for (int i = 0; i < 14 && sts == 0; i++) begin
      post(0, i % 3, 1'b1, 1'b0, 0, 0, sts, at);
      if (sts == 0) begin aops[na] = 2'(i % 3); na++; end
    end
    chk("R5 full status", sts, 2);
    chk("R5 at least depth", 32'(na >= 4), 1);
    idle(LAT * 10 + 20);
    chk("R5 no entry lost", 32'(n - n0), 32'(na));
    for (int i = 0; i < na; i++) chk("R7 order", 32'(eop[n0 + i]), 32'(aops[i]));
    post(1, 1, 1'b1, 1'b0, 0, 0, sts, at);
    chk("R5 lock released after full", sts, 0);
    idle(LAT + 4);

    // R12 R13 sync primitive
    post(0, 2, 1'b1, 1'b0, 0, 0, sts, c0);
    wr(0, A_PRIM, 32'h8);
    acc(1'b0, 0, A_PRIM, 32'd0, q, at, smp);
    chk("R12 sync value", q, 8);
    chk("R12 sync held until drained", 32'(smp), 32'(c0 + 1 + LAT));
    wr(1, A_PRIM, 32'h3);
    rd(1, A_PRIM, q); chk("R13 code 3 ignored", q, 8);
    wr(1, A_PRIM, 32'h18);
    rd(1, A_PRIM, q); chk("R13 code 0x18 ignored", q, 8);
    wr(1, A_PRIM, 32'h9);
    rd(1, A_PRIM, q); chk("R12 prefetch code", q, 9);

    // R9 clear and set on the same edge
    post(1, 0, 1'b1, 1'b1, 0, 0, sts, c0);
    idle(LAT);
    acc(1'b1, 1, A_DONE, 32'h4, q, at, smp);
    chk("R9 clear on retire edge", 32'(at), 32'(c0 + 1 + LAT));
    rd(1, A_DONE, q); chk("R9 set wins", 32'(q[2]), 1);
    wr(1, A_DONE, 32'h4);
    rd(1, A_DONE, q); chk("R9 later clear", 32'(q[2]), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule